// File: doc/BRIEF.md
# Clock ratio detector and reset sequencer

This block runs on the master system clock of an audio converter datapath. It measures how many system clocks fit into one period of the word clock and decides whether that count is one of the four supported oversampling ratios (256, 384, 512 or 768 times the sample rate). It also checks that the word clock stays locked in phase to the system clock, and it controls when the downstream datapath leaves reset.

The internal reset is held low while either the external active-low reset or the power-good level is low. It is released a fixed number of system clocks after both have gone high. The force-bipolar-zero output tells the output stage to sit at mid-scale in three cases: while the internal reset is low, while no valid ratio is locked, and for the word period after a phase slip of the word clock has made the block realign its internal phase counter. The allowed phase slip is measured in bit-clock periods, so the block also measures the bit-clock period in system clocks.

Top module: `clk_ratio_seq`

## Requirements
- R1: A word-clock period of N system clocks is classed as ratio code 0, 1, 2 or 3 when N lies within 2 of 256, 384, 512 or 768. The code is reported on the ratio code output while the ratio is valid.
- R2: While the high-rate input is high, a period near 768 clocks matches no ratio, so code 3 never becomes valid.
- R3: The internal reset output stays low until 1024 rising system-clock edges have sampled both the external reset and power-good high. It goes high on the 1024th such edge.
- R4: Force-bipolar-zero is high on every cycle where the internal reset is low.
- R5: An external reset low level seen by a single system-clock edge drives the internal reset low and restarts the full 1024-clock count.
- R6: The ratio becomes valid after two consecutive word periods that match the same ratio. The reported code does not change while the ratio stays valid.
- R7: A word period that matches no ratio, or a different ratio from the one before, clears the ratio-valid flag and raises force-bipolar-zero. Two new matching periods are needed to restore validity.
- R8: While the ratio is valid, the word-clock phase is compared against an internal counter that wraps at the nominal ratio. If the folded error exceeds 6 measured bit-clock periods, the counter is realigned and force-bipolar-zero stays high until the next word edge whose error is within the limit.
- R9: Once reset is released, the ratio is valid and no realignment is pending, force-bipolar-zero is low.
- R10: A low power-good level acts like the external reset: the internal reset drops and the 1024-clock count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master system clock |
| ext_rst_n_i | input | 1 | External reset, active low, sampled on clk |
| pwr_good_i | input | 1 | Supply-good level, high when power is valid |
| hs_mode_i | input | 1 | High sample-rate mode; disables the 768 ratio |
| wclk_i | input | 1 | Word (left/right) clock |
| bclk_i | input | 1 | Serial bit clock |
| ratio_code_o | output | 2 | Locked ratio: 0=256, 1=384, 2=512, 3=768 |
| ratio_valid_o | output | 1 | High while a ratio is locked |
| int_rst_n_o | output | 1 | Internal datapath reset, active low |
| force_bz_o | output | 1 | Forces the output stage to bipolar zero |

## Verification
The assertions assume that the word and bit clocks are slow compared with the system clock: each high and low phase lasts at least two system clocks, so the synchronizers see every edge. They also assume that the high-rate input changes only between word periods. The bench derives both clocks from a counter stepped on the falling system-clock edge. The word clock is high for the first half of each period, and the bit clock runs freely with a half-period of at least two clocks. Reset inputs and the mode input are changed only on those same falling edges. Expected lock, code and force levels come from a word-level model of the requirements, and each is sampled in the middle of the following word.

// File: rtl/crd_pkg.sv
package crd_pkg;

  typedef enum logic [1:0] {
    RATIO_256 = 2'd0,
    RATIO_384 = 2'd1,
    RATIO_512 = 2'd2,
    RATIO_768 = 2'd3
  } ratio_e;

  typedef struct packed {
    logic   hit;
    ratio_e code;
  } ratio_cls_t;

  // Nominal system clocks per word period for each ratio code
  function automatic int unsigned nominal(ratio_e r);
    case (r)
      RATIO_256: return 256;
      RATIO_384: return 384;
      RATIO_512: return 512;
      default:   return 768;
    endcase
  endfunction

  // Match a measured period against the nominal ratios within +/- tol
  function automatic ratio_cls_t classify(int unsigned len, logic hs, int unsigned tol);
    ratio_cls_t res;
    res.hit  = 1'b0;
    res.code = RATIO_256;
    for (int k = 0; k < 4; k++) begin
      ratio_e      c;
      int unsigned n;
      c = ratio_e'(k[1:0]);
      n = nominal(c);
      if ((len + tol >= n) && (len <= n + tol) && !(hs && (c == RATIO_768))) begin
        res.hit  = 1'b1;
        res.code = c;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/crd_edge.sv
// Synchronizer chain with registered rising-edge pulse
module crd_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o
);

  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      rise_o <= 1'b0;
    end else begin
      sh     <= {sh[STAGES-1:0], din};
      rise_o <= sh[STAGES-1] & ~sh[STAGES];
    end
  end

endmodule

// File: rtl/crd_period.sv
// Counts clocks between ticks; reports each complete period with a strobe
module crd_period #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] per_o,
  output logic         stb_o
);

  logic [W-1:0] cnt;
  logic         seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      seen  <= 1'b0;
      per_o <= '0;
      stb_o <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      if (tick) begin
        cnt  <= '0;
        seen <= 1'b1;
        if (seen) begin
          per_o <= (&cnt) ? cnt : cnt + W'(1);
          stb_o <= 1'b1;
        end
      end else if (!(&cnt)) begin
        cnt <= cnt + W'(1);
      end
    end
  end

endmodule

// File: rtl/crd_rstseq.sv
// Holds the internal reset low for CYCLES clocks after the hard reset clears
module crd_rstseq #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic hard_rst,
  output logic rel_nx_o,
  output logic rel_o
);

  localparam int CW = $clog2(CYCLES);

  logic [CW-1:0] cnt;

  assign rel_nx_o = !hard_rst && (rel_o || (cnt == CW'(CYCLES - 1)));

  always_ff @(posedge clk) begin
    if (hard_rst) begin
      cnt   <= '0;
      rel_o <= 1'b0;
    end else begin
      rel_o <= rel_nx_o;
      if (!rel_o) cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/clk_ratio_seq.sv
module clk_ratio_seq
  import crd_pkg::*;
#(
  parameter int          CNT_W       = 11,
  parameter int unsigned TOL         = 2,
  parameter int          RST_CYCLES  = 1024,
  parameter int unsigned DRIFT_BCK   = 6,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       ext_rst_n_i,
  input  logic       pwr_good_i,
  input  logic       hs_mode_i,
  input  logic       wclk_i,
  input  logic       bclk_i,
  output logic [1:0] ratio_code_o,
  output logic       ratio_valid_o,
  output logic       int_rst_n_o,
  output logic       force_bz_o
);

  localparam int NSRC = 2;  // index 0: word clock, index 1: bit clock

  logic             hard_rst;
  logic [NSRC-1:0]  src_vec;
  logic [NSRC-1:0]  rise;
  logic [NSRC-1:0]  stb;
  logic [CNT_W-1:0] per [NSRC];

  assign hard_rst = !ext_rst_n_i || !pwr_good_i;
  assign src_vec  = {bclk_i, wclk_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    crd_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst    (hard_rst),
      .din    (src_vec[g]),
      .rise_o (rise[g])
    );
    crd_period #(.W(CNT_W)) u_per (
      .clk    (clk),
      .rst    (hard_rst),
      .tick   (rise[g]),
      .per_o  (per[g]),
      .stb_o  (stb[g])
    );
  end

  logic rel_nx, rel_q;

  crd_rstseq #(.CYCLES(RST_CYCLES)) u_rst (
    .clk      (clk),
    .hard_rst (hard_rst),
    .rel_nx_o (rel_nx),
    .rel_o    (rel_q)
  );

  // Lock and phase state
  logic [CNT_W-1:0] bck_len_q;
  logic [CNT_W-1:0] ph_q;
  logic             prev_hit_q, valid_q, resync_q, force_q;
  ratio_e           prev_code_q, ratio_q;

  ratio_cls_t  cls;
  logic        valid_nx, resync_nx, realign;
  ratio_e      ratio_nx;
  int unsigned n_i, ph_i, err_i, thr_i;

  always_comb begin
    cls   = classify(32'(per[0]), hs_mode_i, TOL);
    n_i   = nominal(ratio_q);
    ph_i  = 32'(ph_q);
    err_i = (ph_i <= n_i / 2) ? ph_i : n_i - ph_i;
    thr_i = DRIFT_BCK * 32'(bck_len_q);

    valid_nx  = valid_q;
    resync_nx = resync_q;
    ratio_nx  = ratio_q;
    realign   = 1'b0;
    if (stb[0]) begin
      valid_nx = cls.hit && prev_hit_q && (cls.code == prev_code_q);
      if (valid_nx) ratio_nx = cls.code;
      if (!valid_nx || !valid_q) begin
        realign   = 1'b1;
        resync_nx = 1'b0;
      end else if (err_i > thr_i) begin
        realign   = 1'b1;
        resync_nx = 1'b1;
      end else begin
        resync_nx = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hard_rst) begin
      bck_len_q   <= '0;
      ph_q        <= '0;
      prev_hit_q  <= 1'b0;
      prev_code_q <= RATIO_256;
      valid_q     <= 1'b0;
      ratio_q     <= RATIO_256;
      resync_q    <= 1'b0;
      force_q     <= 1'b1;
    end else begin
      if (stb[1]) bck_len_q <= per[1];
      if (stb[0]) begin
        prev_hit_q  <= cls.hit;
        prev_code_q <= cls.code;
      end
      if (realign)                ph_q <= CNT_W'(1);
      else if (ph_i + 1 >= n_i)   ph_q <= '0;
      else                        ph_q <= ph_q + CNT_W'(1);
      valid_q  <= valid_nx;
      ratio_q  <= ratio_nx;
      resync_q <= resync_nx;
      force_q  <= !rel_nx || !valid_nx || resync_nx;
    end
  end

  assign ratio_code_o  = ratio_q;
  assign ratio_valid_o = valid_q;
  assign int_rst_n_o   = rel_q;
  assign force_bz_o    = force_q;

endmodule

// File: rtl/crd_checker.sv
module crd_checker #(
  parameter int RST_CYCLES = 1024
) (
  input logic       clk,
  input logic       ext_rst_n_i,
  input logic       pwr_good_i,
  input logic       hs_mode_i,
  input logic [1:0] ratio_code_o,
  input logic       ratio_valid_o,
  input logic       int_rst_n_o,
  input logic       force_bz_o
);

  localparam int WW = $clog2(RST_CYCLES + 1);

  logic          hard_rst;
  logic [WW-1:0] win;

  assign hard_rst = !ext_rst_n_i || !pwr_good_i;

  // Clocks since the hard reset cleared, saturating at the release count
  always_ff @(posedge clk) begin
    if (hard_rst)                     win <= '0;
    else if (win != WW'(RST_CYCLES))  win <= win + WW'(1);
  end

  AST_RELEASE_WINDOW: assert property (@(posedge clk) disable iff (hard_rst)
    int_rst_n_o == (win == WW'(RST_CYCLES))); // R3

  AST_RST_FORCES_MID: assert property (@(posedge clk) disable iff (hard_rst)
    !int_rst_n_o |-> force_bz_o); // R4

  AST_PULSE_RESTARTS: assert property (@(posedge clk) disable iff (!pwr_good_i)
    !ext_rst_n_i |=> !int_rst_n_o); // R5

  AST_PGOOD_RESTARTS: assert property (@(posedge clk) disable iff (!ext_rst_n_i)
    !pwr_good_i |=> !int_rst_n_o); // R10

  AST_INVALID_FORCES: assert property (@(posedge clk) disable iff (hard_rst)
    !ratio_valid_o |-> force_bz_o); // R7

  AST_NO_768_HS: assert property (@(posedge clk) disable iff (hard_rst)
    $rose(ratio_valid_o) |-> !(hs_mode_i && ratio_code_o == 2'd3)); // R2

  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (hard_rst)
    (ratio_valid_o && $past(ratio_valid_o)) |-> $stable(ratio_code_o)); // R6

endmodule

bind clk_ratio_seq crd_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk           (clk),
  .ext_rst_n_i   (ext_rst_n_i),
  .pwr_good_i    (pwr_good_i),
  .hs_mode_i     (hs_mode_i),
  .ratio_code_o  (ratio_code_o),
  .ratio_valid_o (ratio_valid_o),
  .int_rst_n_o   (int_rst_n_o),
  .force_bz_o    (force_bz_o)
);

// File: tb/sim_clk_ratio_seq.sv
module sim_clk_ratio_seq;

  logic       clk = 1'b0;
  logic       ext_rst_n_i, pwr_good_i, hs_mode_i, wclk_i, bclk_i;
  logic [1:0] ratio_code_o;
  logic       ratio_valid_o, int_rst_n_o, force_bz_o;

  always #4 clk = ~clk;

  clk_ratio_seq u0 (
    .clk           (clk),
    .ext_rst_n_i   (ext_rst_n_i),
    .pwr_good_i    (pwr_good_i),
    .hs_mode_i     (hs_mode_i),
    .wclk_i        (wclk_i),
    .bclk_i        (bclk_i),
    .ratio_code_o  (ratio_code_o),
    .ratio_valid_o (ratio_valid_o),
    .int_rst_n_o   (int_rst_n_o),
    .force_bz_o    (force_bz_o)
  );

  int errors = 0;
  int checks = 0;
  int bck    = 4;
  int bcnt   = 0;

  // Word-level model state
  bit m_valid = 0, m_resync = 0, m_prev_hit = 0, have_prev = 0;
  int m_code = 0, m_prev_code = -1, m_acc = 0, prev_p = 0;
  int seen_resync = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  function automatic int nom_of(input int c);
    return (c == 0) ? 256 : (c == 1) ? 384 : (c == 2) ? 512 : 768;
  endfunction

  function automatic int code_of(input int p, input bit hs);
    for (int c = 0; c < 4; c++) begin
      if (p >= nom_of(c) - 2 && p <= nom_of(c) + 2 && !(hs && c == 3)) return c;
    end
    return -1;
  endfunction

  task automatic tick();
    @(negedge clk);
    bcnt   = (bcnt + 1 >= bck) ? 0 : bcnt + 1;
    bclk_i = (bcnt < bck / 2);
  endtask

  task automatic model_update(input int p);
    int c;
    bit vnx;
    c   = code_of(p, hs_mode_i);
    vnx = (c >= 0) && m_prev_hit && (c == m_prev_code);
    if (!vnx || !m_valid) begin
      m_acc    = 0;
      m_resync = 0;
    end else begin
      int n, e;
      n     = nom_of(m_code);
      m_acc = (m_acc + p) % n;
      e     = (m_acc <= n / 2) ? m_acc : n - m_acc;
      if (e > 6 * bck) begin
        m_resync = 1;
        m_acc    = 0;
      end else begin
        m_resync = 0;
      end
    end
    if (vnx) m_code = c;
    m_valid     = vnx;
    m_prev_hit  = (c >= 0);
    m_prev_code = c;
  endtask

  task automatic check_state();
    chk("R6 ratio valid", int'(ratio_valid_o), int'(m_valid));
    if (m_resync) chk("R8 force during realign", int'(force_bz_o), 1);
    else if (!m_valid) chk("R7 force while unlocked", int'(force_bz_o), 1);
    else chk("R9 force released", int'(force_bz_o), 0);
    if (m_valid) chk("R1 ratio code", int'(ratio_code_o), m_code);
    if (ratio_valid_o && force_bz_o) seen_resync++;
  endtask

  task automatic word(input int p);
    if (have_prev) model_update(prev_p);
    for (int i = 0; i < p; i++) begin
      tick();
      wclk_i = (i < p / 2);
      if (i == p / 2 && have_prev) check_state();
    end
    prev_p    = p;
    have_prev = 1;
  endtask

  task automatic rst_window(input string tag);
    ext_rst_n_i = 1'b1;
    pwr_good_i  = 1'b1;
    chk({tag, " reset asserted"}, int'(int_rst_n_o), 0);
    repeat (1023) tick();
    chk("R3 still held at 1023", int'(int_rst_n_o), 0);
    chk("R4 forced mid-scale in reset", int'(force_bz_o), 1);
    tick();
    chk("R3 released at 1024", int'(int_rst_n_o), 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    ext_rst_n_i = 1'b0;
    pwr_good_i  = 1'b1;
    hs_mode_i   = 1'b0;
    wclk_i      = 1'b0;
    bclk_i      = 1'b0;
    repeat (4) tick();
    chk("R3 reset state int reset", int'(int_rst_n_o), 0);
    chk("R4 reset state force", int'(force_bz_o), 1);
    chk("R6 reset state valid", int'(ratio_valid_o), 0);
    rst_window("R3");

    // R5: one-clock external reset pulse restarts the count
    tick(); ext_rst_n_i = 1'b0;
    tick();
    rst_window("R5");

    // R10: power-good dip behaves as a reset
    tick(); pwr_good_i = 1'b0;
    tick();
    rst_window("R10");

    // R1 / R6 / R9: exact 256 periods
    bck = 4;
    repeat (6) word(256);

    // R8: steady +2 offset accumulates phase error until realignment
    seen_resync = 0;
    repeat (18) word(258);
    chk("R8 realign observed at ports", int'(seen_resync > 0), 1);

    // R7: single bad period then recovery after two matches
    repeat (3) word(256);
    word(300);
    repeat (3) word(256);

    // R1: other ratios
    bck = 6;  repeat (5) word(384);
    bck = 8;  repeat (5) word(512);
    bck = 12; repeat (5) word(768);

    // R2: 768 rejected in high-rate mode
    hs_mode_i = 1'b1;
    repeat (5) word(768);
    chk("R2 no lock at 768 in high-rate mode", int'(ratio_valid_o), 0);
    hs_mode_i = 1'b0;

    // Random segments with jitter that sometimes leaves the tolerance
    for (int s = 0; s < 6; s++) begin
      int c, base;
      c    = int'($urandom_range(0, 3));
      base = nom_of(c);
      hs_mode_i = ($urandom_range(0, 3) == 0);
      bck  = base / 64;
      for (int w = 0; w < 8; w++) begin
        word(base + int'($urandom_range(0, 8)) - 4);
      end
    end
    hs_mode_i = 1'b0;
    repeat (2) word(256);

    summary();
    $finish;
  end

endmodule